// File: doc/BRIEF.md
# Conversion Result Store with Auto-Advancing Readout

This block keeps the sixteen most recent signed results from an analog converter and gives a register bus a way to read them back. The converter side places a 13-bit two's-complement result into any of the sixteen slots. Along with the value, it passes the channel code and the differential-select bit that produced it. From these the block records two flags for the slot: whether it is a temperature reading and whether it was taken differentially. The bus cannot write the slots. A reset clears all of them to zero.

The bus sees two addresses. Address 0 is a control word. Its low fields hold a slot pointer, an alignment choice and a source-select bit, and two read-only flag bits show how the slot under the pointer was measured. Address 1 is the data port. While the source-select bit is 0, a read of the data port returns the slot under the pointer as a 16-bit word and moves the pointer on by one. A run of reads therefore walks the whole store without any rewrite of the pointer. While the source-select bit is 1, the data port reads as zero and the pointer does not move. Read data is registered and becomes valid one clock after the read strobe.

Top module: `conv_result_store`

## Requirements
- R1: After reset the read data output is 0, the control word reads 0, and every slot reads back as 0.
- R2: With alignment bit (control bit 4) at 0, a data read returns the 13-bit result in bits 12:0, with bits 15:13 each equal to result bit 12.
- R3: With alignment bit at 1, a data read returns the 13-bit result in bits 15:3, with bits 2:0 equal to 0.
- R4: Each data read with source-select (control bit 5) at 0 adds one to the 4-bit pointer (control bits 3:0). The pointer wraps from 15 to 0.
- R5: Read data appears on the output in the clock after the read strobe and holds its value until the next read.
- R6: With source-select at 1, a data read returns 0 and leaves the pointer unchanged.
- R7: A bus write to the data address (address 1) changes no slot.
- R8: When a conversion write to the slot under the pointer coincides with a data read, the read returns the slot's previous contents and the pointer still advances. A later read returns the new value.
- R9: Control bit 6 shows the temperature flag and bit 7 the differential flag of the slot under the pointer. Channel codes 110 and 111 set both flags whatever the differential-select bit is. Codes 000 to 101 clear the temperature flag and copy the differential-select bit into the differential flag.
- R10: Negative results are stored and returned unchanged, without clamping, in both alignments.
- R11: A bus write to address 0 loads the pointer, alignment and source-select from write data bits 3:0, 4 and 5. Bits 7:6 are read-only and are not affected by the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| busAddr | input | 1 | Register address: 0 control word, 1 data port |
| busWrEn | input | 1 | Bus write strobe |
| busRdEn | input | 1 | Bus read strobe |
| busWdata | input | 16 | Bus write data |
| busRdata | output | 16 | Registered bus read data |
| convWrEn | input | 1 | Conversion result write strobe |
| convSlot | input | 4 | Destination slot of the conversion result |
| convChan | input | 3 | Channel code of the conversion |
| convDiff | input | 1 | Differential-select bit of the conversion |
| convResult | input | 13 | Signed conversion result |

## Verification
The hardest case to reach from the ports is a conversion write that lands on the slot under the pointer in the same clock as a data read. Two things must hold at once in that cycle: the old contents come out and the pointer still moves. The stimulus first positions the pointer through a control write, then raises both strobes on one clock edge. A later re-aim and re-read confirms that the new value did reach storage. Pointer wrap is reached by reading all sixteen slots in a row and then continuing past the last one.

// File: rtl/crs_pkg.sv
package crs_pkg;
  parameter int DEPTH  = 16;
  parameter int IDX_W  = $clog2(DEPTH);
  parameter int RES_W  = 13;
  parameter int DATA_W = 16;
  parameter int CHAN_W = 3;

  // strobes and state handed from control to datapath
  typedef struct packed {
    logic             rdBuf;
    logic             rdCtrl;
    logic             rdZero;
    logic [IDX_W-1:0] index;
    logic             alignLeft;
    logic             cfgSel;
  } strobe_t;
endpackage

// File: rtl/crs_ctrl.sv
module crs_ctrl
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWdata,
  output strobe_t           strb
);
  localparam int ALIGN_BIT = IDX_W;
  localparam int CFG_BIT   = IDX_W + 1;

  logic [IDX_W-1:0] indexQ;
  logic             alignQ;
  logic             cfgQ;
  logic             ctrlWr;
  logic             dataRd;

  assign ctrlWr = busWrEn && (busAddr == 1'b0);
  assign dataRd = busRdEn && (busAddr == 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      indexQ <= '0;
      alignQ <= 1'b0;
      cfgQ   <= 1'b0;
    end else if (ctrlWr) begin
      indexQ <= busWdata[IDX_W-1:0];
      alignQ <= busWdata[ALIGN_BIT];
      cfgQ   <= busWdata[CFG_BIT];
    end else if (dataRd && !cfgQ) begin
      indexQ <= indexQ + 1'b1;  // natural wrap at DEPTH
    end
  end

  always_comb begin
    strb.rdBuf     = dataRd && !cfgQ;
    strb.rdZero    = dataRd && cfgQ;
    strb.rdCtrl    = busRdEn && (busAddr == 1'b0);
    strb.index     = indexQ;
    strb.alignLeft = alignQ;
    strb.cfgSel    = cfgQ;
  end
endmodule

// File: rtl/crs_datapath.sv
module crs_datapath
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              convWrEn,
  input  logic [IDX_W-1:0]  convSlot,
  input  logic [CHAN_W-1:0] convChan,
  input  logic              convDiff,
  input  logic [RES_W-1:0]  convResult,
  output logic [DATA_W-1:0] busRdata
);
  localparam int PAD_W  = DATA_W - RES_W;
  localparam int CTRL_W = IDX_W + 4;

  logic [RES_W-1:0] resultMem [DEPTH];
  logic [DEPTH-1:0] tempMem;
  logic [DEPTH-1:0] diffMem;

  logic             newTemp;
  logic             newDiff;
  logic [RES_W-1:0] curRes;
  logic [DATA_W-1:0] fmtWord;
  logic [DATA_W-1:0] ctrlWord;

  // codes 11X mean internal temperature, always differential
  assign newTemp = convChan[CHAN_W-1] & convChan[CHAN_W-2];
  assign newDiff = newTemp | convDiff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) resultMem[i] <= '0;
      tempMem <= '0;
      diffMem <= '0;
    end else if (convWrEn) begin
      resultMem[convSlot] <= convResult;
      tempMem[convSlot]   <= newTemp;
      diffMem[convSlot]   <= newDiff;
    end
  end

  assign curRes = resultMem[strb.index];

  always_comb begin
    if (strb.alignLeft) fmtWord = {curRes, {PAD_W{1'b0}}};
    else                fmtWord = {{PAD_W{curRes[RES_W-1]}}, curRes};
    ctrlWord = {{(DATA_W-CTRL_W){1'b0}}, diffMem[strb.index], tempMem[strb.index],
                strb.cfgSel, strb.alignLeft, strb.index};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busRdata <= '0;
    else if (strb.rdBuf)  busRdata <= fmtWord;
    else if (strb.rdCtrl) busRdata <= ctrlWord;
    else if (strb.rdZero) busRdata <= '0;
  end
endmodule

// File: rtl/conv_result_store.sv
module conv_result_store
  import crs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              convWrEn,
  input  logic [IDX_W-1:0]  convSlot,
  input  logic [CHAN_W-1:0] convChan,
  input  logic              convDiff,
  input  logic [RES_W-1:0]  convResult
);
  strobe_t          strb;
  logic [IDX_W-1:0] curIndex;
  logic             cfgSel;
  logic             alignLeft;

  assign curIndex  = strb.index;
  assign cfgSel    = strb.cfgSel;
  assign alignLeft = strb.alignLeft;

  crs_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busRdEn  (busRdEn),
    .busWdata (busWdata),
    .strb     (strb)
  );

  crs_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .convWrEn   (convWrEn),
    .convSlot   (convSlot),
    .convChan   (convChan),
    .convDiff   (convDiff),
    .convResult (convResult),
    .busRdata   (busRdata)
  );
endmodule

// File: rtl/crs_checker.sv
module crs_checker
  import crs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busAddr,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [DATA_W-1:0] busRdata,
  input logic [IDX_W-1:0]  curIndex,
  input logic              cfgSel,
  input logic              alignLeft
);
  localparam int PAD_W = DATA_W - RES_W;

  logic bufRead;
  assign bufRead = busRdEn && busAddr && !cfgSel && !busWrEn;

  p_index_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    bufRead |=> curIndex == IDX_W'($past(curIndex) + 1'b1));

  p_index_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr && cfgSel && !busWrEn) |=> $stable(curIndex));

  p_zero_word_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr && cfgSel) |=> busRdata == '0);

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> $stable(busRdata));

  p_low_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (bufRead && alignLeft) |=> busRdata[PAD_W-1:0] == '0);

  p_sign_fill_r2: assert property (@(posedge clk) disable iff (!rstN)
    (bufRead && !alignLeft) |=>
      busRdata[DATA_W-1:RES_W] == {PAD_W{busRdata[RES_W-1]}});
endmodule

bind conv_result_store crs_checker u_chk (.*);

// File: tb/sim_conv_result_store.sv
`timescale 1ns/1ps
module sim_conv_result_store;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busAddr = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        convWrEn = 1'b0;
  logic [3:0]  convSlot = '0;
  logic [2:0]  convChan = '0;
  logic        convDiff = 1'b0;
  logic [12:0] convResult = '0;

  always #2 clk = ~clk;  // 250 MHz

  conv_result_store u0 (.*);

  typedef struct { logic [15:0] v; string r; } item_t;
  item_t q[$];
  item_t it;

  int nRun = 0, nFail = 0;
  logic done = 1'b0;

  // bench model of the requirements
  logic [12:0] mRes [16];
  logic        mTemp [16];
  logic        mDiff [16];
  logic [3:0]  mIdx = '0;
  logic        mAlign = 1'b0, mCfg = 1'b0;
  logic [15:0] lastExp = '0;

  task automatic chk(string r, logic [15:0] act, logic [15:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  function automatic logic [15:0] fmt(logic [12:0] v, logic left);
    return left ? {v, 3'b000} : {{3{v[12]}}, v};
  endfunction

  function automatic logic [15:0] ctrlExp();
    return {8'h00, mDiff[mIdx], mTemp[mIdx], mCfg, mAlign, mIdx};
  endfunction

  // monitor: pops one expected item per read strobe
  always @(posedge clk) begin
    if (busRdEn) begin
      #1;
      if (q.size() == 0) chk("scoreboard-empty", 16'h0, 16'h1);
      else begin
        it = q.pop_front();
        chk(it.r, busRdata, it.v);
      end
    end
  end

  task automatic push(logic [15:0] v, string r);
    item_t x;
    x.v = v; x.r = r;
    q.push_back(x);
    lastExp = v;
  endtask

  task automatic convWrite(int slot, logic [2:0] ch, logic df, logic [12:0] v);
    @(negedge clk);
    convWrEn = 1; convSlot = 4'(slot); convChan = ch; convDiff = df; convResult = v;
    @(negedge clk);
    convWrEn = 0;
    mRes[slot]  = v;
    mTemp[slot] = ch[2] & ch[1];
    mDiff[slot] = (ch[2] & ch[1]) | df;
  endtask

  task automatic busWrite(logic a, logic [15:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1; busWdata = d;
    @(negedge clk);
    busWrEn = 0;
    if (!a) begin
      mIdx = d[3:0]; mAlign = d[4]; mCfg = d[5];
    end
  endtask

  task automatic readData(string r);
    @(negedge clk);
    busAddr = 1; busRdEn = 1;
    if (mCfg) push(16'h0, r);
    else begin
      push(fmt(mRes[mIdx], mAlign), r);
      mIdx = mIdx + 1'b1;
    end
    @(negedge clk);
    busRdEn = 0;
  endtask

  task automatic readCtrl(string r);
    @(negedge clk);
    busAddr = 0; busRdEn = 1;
    push(ctrlExp(), r);
    @(negedge clk);
    busRdEn = 0;
  endtask

  // R8: conversion write to the pointed slot in the read cycle
  task automatic readWithConv(logic [12:0] v, string r);
    int s;
    @(negedge clk);
    s = int'(mIdx);
    busAddr = 1; busRdEn = 1;
    convWrEn = 1; convSlot = mIdx; convChan = 3'b001; convDiff = 0; convResult = v;
    push(fmt(mRes[s], mAlign), r);
    mIdx = mIdx + 1'b1;
    @(negedge clk);
    busRdEn = 0; convWrEn = 0;
    mRes[s] = v; mTemp[s] = 0; mDiff[s] = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin mRes[i] = '0; mTemp[i] = 0; mDiff[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    chk("R1 reset output", busRdata, 16'h0);
    readCtrl("R1 control word after reset");
    readData("R1 slot 0 after reset");
    readData("R1 slot 1 after reset");

    // fill every slot; mix of channels, modes and signs (R10 negatives)
    for (int i = 0; i < 16; i++)
      convWrite(i, 3'(i % 8), i[1], 13'(i * 611 - 4000));
    convWrite(0, 3'b000, 1'b0, 13'h1FFF);  // single-ended -1, R10

    // R9 flags per slot
    for (int i = 0; i < 16; i++) begin
      busWrite(0, 16'(i));
      readCtrl("R9 flags of pointed slot");
    end

    // R2 right aligned walk, R4 advance and wrap, R10 negatives unclamped
    busWrite(0, 16'h0000);
    for (int i = 0; i < 16; i++) readData("R2/R4/R10 right aligned walk");
    readCtrl("R4 pointer wrapped to 0");
    readData("R4 read after wrap");

    // R3 left aligned across the wrap
    busWrite(0, 16'h001E);
    for (int i = 0; i < 4; i++) readData("R3/R10 left aligned walk");
    readCtrl("R4 pointer after left walk");

    // R5 output holds between reads
    repeat (4) @(negedge clk);
    chk("R5 data held while idle", busRdata, lastExp);

    // R6 source-select set
    busWrite(0, 16'h0025);
    readData("R6 zero while selected away");
    readData("R6 zero while selected away");
    readCtrl("R6 pointer unchanged");

    // R7 data-address writes ignored in both selections
    busWrite(1, 16'h7FFF);
    busWrite(0, 16'h0005);
    busWrite(1, 16'h1234);
    readData("R7 slot 5 unchanged");
    readData("R7 slot 6 unchanged");

    // R8 coincident conversion write and read
    busWrite(0, 16'h0009);
    readWithConv(13'h0ABC, "R8 old contents returned");
    readCtrl("R8 pointer still advanced");
    busWrite(0, 16'h0009);
    readData("R8 new contents stored");

    // R11 read-only flag bits ignore writes
    busWrite(0, 16'hFFC7);
    readCtrl("R11 control fields loaded, flags read-only");
    busWrite(0, 16'h0000);
    readCtrl("R11 control cleared");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule